// File: doc/BRIEF.md
# Overflow and Carry Latch Unit

This block keeps the two single-bit arithmetic status flags that sit beside a 16-bit two's complement adder. The overflow flag is sticky: it is raised by a signed add or subtract that leaves the accumulator's range, by a divide whose quotient cannot fit, or by an explicit set command. It then holds until a test command reads it. The test command asks the program counter to skip one instruction when no overflow is present, and it clears the flag in the same step.

The carry flag links the two halves of a double-precision add or subtract. A copy-sign command loads it from the sign bit of the low-order accumulator and asks for that sign bit to be written back as zero. The next high-word add uses the flag as carry-in. The next high-word subtract uses its inverse, which takes off the borrow. The flag is wiped at the end of every instruction other than the copy-sign one, so the high-word operation must come right after it. Words are numbered with bit 0 as the sign and bit 15 as the least significant bit.

Top module: `arith_status_latches`

## Requirements
- R1: While reset is asserted (rst_n low, synchronous), and on the first cycle after it, ovf_q, carry_q and skip_req are 0.
- R2: On an add strobe, when a_sign equals opnd_sign and sum_sign differs from a_sign, ovf_q is 1 after the clock edge. Otherwise the add leaves ovf_q unchanged.
- R3: On a subtract strobe (A minus operand), when a_sign differs from opnd_sign and sum_sign differs from a_sign, ovf_q is 1 after the edge. Otherwise the subtract leaves ovf_q unchanged.
- R4: On a divide strobe, ovf_q is set when the magnitude of div_divisor is less than or equal to the magnitude of div_high. Both are two's complement words with bit 0 as the sign, and the magnitude of the most negative value is 32768.
- R5: ovf_set_stb sets ovf_q unconditionally at the next edge.
- R6: Once ovf_q is 1, it stays 1 on every cycle without a test strobe.
- R7: A test strobe clears ovf_q at the next edge. In the cycle after the test, skip_req is 1 for exactly one cycle if ovf_q was 0 when the test was sampled. If a set source is active in the same cycle as the test, the set wins.
- R8: sign_copy_stb loads carry_q from b_sign at the next edge and drives b_sign_clr high in the same cycle. b_sign_clr is low in every other cycle.
- R9: carry_in equals carry_q, except while sub_stb is high, when it equals the inverse of carry_q.
- R10: instr_end clears carry_q at the next edge unless sign_copy_stb was seen in the same cycle, or since the previous instr_end. With neither strobe, carry_q holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| add_stb | input | 1 | Add result is on the sign inputs |
| sub_stb | input | 1 | Subtract result is on the sign inputs |
| div_stb | input | 1 | Divide overflow check this cycle |
| ovf_set_stb | input | 1 | Force the overflow flag on |
| ovf_test_stb | input | 1 | Test-and-clear of the overflow flag |
| sign_copy_stb | input | 1 | Copy the low accumulator sign into the carry flag |
| instr_end | input | 1 | Last cycle of an instruction |
| a_sign | input | 1 | Sign of the A accumulator operand |
| opnd_sign | input | 1 | Sign of the memory operand |
| sum_sign | input | 1 | Sign of the adder result |
| b_sign | input | 1 | Bit 0 of the B accumulator |
| div_high | input | 16 | High-order dividend word, bit 0 is the sign |
| div_divisor | input | 16 | Divisor word, bit 0 is the sign |
| ovf_q | output | 1 | Overflow flag |
| carry_q | output | 1 | Carry flag |
| carry_in | output | 1 | Carry into the adder's least significant bit |
| b_sign_clr | output | 1 | Write zero into bit 0 of B |
| skip_req | output | 1 | One-cycle request to advance the PC by two |

## Verification
The assertions assume that the decoder never raises add_stb and sub_stb in the same cycle. They also assume that the sign inputs are valid whenever either of those strobes is high. The bench drives one decoded strobe set per cycle and never pairs add with subtract. Where it overlaps strobes on purpose, it uses only the pairs the requirements define: test with set, and copy-sign with instruction end. Divide operands include zero, equal magnitudes, a negative divisor and the most negative word, so that the magnitude rule is exercised where it is tight.

// File: rtl/afu_pkg.sv
`timescale 1ns/1ps
package afu_pkg;
  parameter int unsigned WORD_W = 16;

  typedef struct packed {
    logic add_ovf;
    logic sub_ovf;
    logic div_ovf;
    logic forced;
  } ovf_src_t;
endpackage

// File: rtl/afu_ovf_detect.sv
`timescale 1ns/1ps
module afu_ovf_detect
  import afu_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         add_stb,
  input  logic         sub_stb,
  input  logic         div_stb,
  input  logic         ovf_set_stb,
  input  logic         a_sign,
  input  logic         opnd_sign,
  input  logic         sum_sign,
  input  logic [0:W-1] div_high,
  input  logic [0:W-1] div_divisor,
  output ovf_src_t     src
);
  typedef logic [0:W-1] word_t;

  // Signed add overflow: the operands agree in sign and the result does not.
  function automatic logic add_wraps(input logic sa, input logic so, input logic sr);
    return (sa == so) && (sr != sa);
  endfunction

  // Signed subtract overflow, A minus operand: the operands differ in sign
  // and the result left A's sign.
  function automatic logic sub_wraps(input logic sa, input logic so, input logic sr);
    return (sa != so) && (sr != sa);
  endfunction

  // Unsigned magnitude; the most negative word maps onto its own bit pattern.
  function automatic word_t mag(input word_t w);
    return w[0] ? (~w) + word_t'(1) : w;
  endfunction

  function automatic logic quot_too_big(input word_t hi, input word_t dv);
    return mag(dv) <= mag(hi);
  endfunction

  always_comb begin
    src.add_ovf = add_stb && add_wraps(a_sign, opnd_sign, sum_sign);
    src.sub_ovf = sub_stb && sub_wraps(a_sign, opnd_sign, sum_sign);
    src.div_ovf = div_stb && quot_too_big(div_high, div_divisor);
    src.forced  = ovf_set_stb;
  end
endmodule

// File: rtl/afu_ovf_latch.sv
`timescale 1ns/1ps
module afu_ovf_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic test,
  output logic ovf_q,
  output logic skip_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q    <= 1'b0;
      skip_req <= 1'b0;
    end else begin
      if (raise)     ovf_q <= 1'b1;
      else if (test) ovf_q <= 1'b0;
      skip_req <= test && !ovf_q;
    end
  end
endmodule

// File: rtl/afu_carry_latch.sv
`timescale 1ns/1ps
module afu_carry_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic copy,
  input  logic instr_end,
  input  logic b_sign,
  input  logic sub_stb,
  output logic carry_q,
  output logic carry_in,
  output logic b_sign_clr,
  output logic wipe
);
  logic pend_q;

  assign wipe = instr_end && !copy && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (copy)      carry_q <= b_sign;
      else if (wipe) carry_q <= 1'b0;
      if (instr_end) pend_q <= 1'b0;
      else if (copy) pend_q <= 1'b1;
    end
  end

  assign carry_in   = sub_stb ? !carry_q : carry_q;
  assign b_sign_clr = copy;
endmodule

// File: rtl/arith_status_latches.sv
`timescale 1ns/1ps
module arith_status_latches
  import afu_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_stb,
  input  logic         sub_stb,
  input  logic         div_stb,
  input  logic         ovf_set_stb,
  input  logic         ovf_test_stb,
  input  logic         sign_copy_stb,
  input  logic         instr_end,
  input  logic         a_sign,
  input  logic         opnd_sign,
  input  logic         sum_sign,
  input  logic         b_sign,
  input  logic [0:W-1] div_high,
  input  logic [0:W-1] div_divisor,
  output logic         ovf_q,
  output logic         carry_q,
  output logic         carry_in,
  output logic         b_sign_clr,
  output logic         skip_req
);
  ovf_src_t ovf_src;
  logic     ovf_raise;
  logic     carry_wipe;

  afu_ovf_detect #(.W(W)) u_det (
    .add_stb(add_stb), .sub_stb(sub_stb), .div_stb(div_stb),
    .ovf_set_stb(ovf_set_stb), .a_sign(a_sign), .opnd_sign(opnd_sign),
    .sum_sign(sum_sign), .div_high(div_high), .div_divisor(div_divisor),
    .src(ovf_src)
  );

  assign ovf_raise = |ovf_src;

  afu_ovf_latch u_ovf (
    .clk(clk), .rst_n(rst_n), .raise(ovf_raise), .test(ovf_test_stb),
    .ovf_q(ovf_q), .skip_req(skip_req)
  );

  afu_carry_latch u_cry (
    .clk(clk), .rst_n(rst_n), .copy(sign_copy_stb), .instr_end(instr_end),
    .b_sign(b_sign), .sub_stb(sub_stb), .carry_q(carry_q),
    .carry_in(carry_in), .b_sign_clr(b_sign_clr), .wipe(carry_wipe)
  );
endmodule

// File: rtl/afu_checker.sv
`timescale 1ns/1ps
module afu_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         add_stb,
  input logic         sub_stb,
  input logic         div_stb,
  input logic         ovf_set_stb,
  input logic         ovf_test_stb,
  input logic         sign_copy_stb,
  input logic         instr_end,
  input logic         a_sign,
  input logic         opnd_sign,
  input logic         sum_sign,
  input logic         b_sign,
  input logic [0:W-1] div_divisor,
  input logic         ovf_q,
  input logic         carry_q,
  input logic         carry_in,
  input logic         b_sign_clr,
  input logic         skip_req,
  input logic         ovf_raise
);
  // Checker-side record of a copy-sign seen since the last instruction end.
  logic pend_m;
  always_ff @(posedge clk) begin
    if (!rst_n)             pend_m <= 1'b0;
    else if (instr_end)     pend_m <= 1'b0;
    else if (sign_copy_stb) pend_m <= 1'b1;
  end

  p_add_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    add_stb && !sub_stb && (a_sign == opnd_sign) && (sum_sign != a_sign) |=> ovf_q);
  p_sub_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb && !add_stb && (a_sign != opnd_sign) && (sum_sign != a_sign) |=> ovf_q);
  p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb && (div_divisor == '0) |=> ovf_q);
  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set_stb |=> ovf_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !ovf_test_stb |=> ovf_q);
  p_test_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_test_stb && !ovf_raise |=> !ovf_q);
  p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_test_stb && !ovf_q |=> skip_req);
  p_skip_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> $past(ovf_test_stb));
  p_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sign_copy_stb |=> carry_q == $past(b_sign));
  p_bclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    b_sign_clr == sign_copy_stb);
  p_cin_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |-> carry_in != carry_q);
  p_cin_add_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_stb |-> carry_in == carry_q);
  p_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end && !sign_copy_stb && !pend_m |=> !carry_q);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_copy_stb && !instr_end |=> $stable(carry_q));
endmodule

bind arith_status_latches afu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_stb(add_stb), .sub_stb(sub_stb),
  .div_stb(div_stb), .ovf_set_stb(ovf_set_stb), .ovf_test_stb(ovf_test_stb),
  .sign_copy_stb(sign_copy_stb), .instr_end(instr_end), .a_sign(a_sign),
  .opnd_sign(opnd_sign), .sum_sign(sum_sign), .b_sign(b_sign),
  .div_divisor(div_divisor), .ovf_q(ovf_q), .carry_q(carry_q),
  .carry_in(carry_in), .b_sign_clr(b_sign_clr), .skip_req(skip_req),
  .ovf_raise(ovf_raise)
);

// File: tb/sim_arith_status_latches.sv
`timescale 1ns/1ps
module sim_arith_status_latches;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic add_stb = 0, sub_stb = 0, div_stb = 0, ovf_set_stb = 0, ovf_test_stb = 0;
  logic sign_copy_stb = 0, instr_end = 0, a_sign = 0, opnd_sign = 0, sum_sign = 0, b_sign = 0;
  logic [0:15] div_high = '0, div_divisor = '0;
  logic ovf_q, carry_q, carry_in, b_sign_clr, skip_req;

  int checks = 0;
  int failures = 0;

  typedef struct {
    bit    ovf, carry, skip, cin, bclr;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference state, kept from the requirements.
  bit m_ovf = 0, m_carry = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  arith_status_latches u0 (
    .clk(clk), .rst_n(rst_n), .add_stb(add_stb), .sub_stb(sub_stb),
    .div_stb(div_stb), .ovf_set_stb(ovf_set_stb), .ovf_test_stb(ovf_test_stb),
    .sign_copy_stb(sign_copy_stb), .instr_end(instr_end), .a_sign(a_sign),
    .opnd_sign(opnd_sign), .sum_sign(sum_sign), .b_sign(b_sign),
    .div_high(div_high), .div_divisor(div_divisor), .ovf_q(ovf_q),
    .carry_q(carry_q), .carry_in(carry_in), .b_sign_clr(b_sign_clr),
    .skip_req(skip_req)
  );

  function automatic int magn(input logic [0:15] w);
    int v = $signed(w);
    return (v < 0) ? -v : v;
  endfunction

  // Driver: applies one cycle of strobes and queues what must follow.
  task automatic drive(input bit ad, input bit sb, input bit dv, input bit st,
                       input bit ts, input bit cp, input bit en,
                       input bit sa, input bit so, input bit sr, input bit bs,
                       input logic [0:15] hi, input logic [0:15] dr,
                       input string tag);
    exp_t e;
    bit ev;
    @(negedge clk);
    add_stb = ad; sub_stb = sb; div_stb = dv; ovf_set_stb = st;
    ovf_test_stb = ts; sign_copy_stb = cp; instr_end = en;
    a_sign = sa; opnd_sign = so; sum_sign = sr; b_sign = bs;
    div_high = hi; div_divisor = dr;
    e.cin  = sb ? !m_carry : m_carry;
    e.bclr = cp;
    ev = st || (ad && sa == so && sr != sa) || (sb && sa != so && sr != sa)
         || (dv && magn(dr) <= magn(hi));
    e.skip = ts && !m_ovf;
    if (ev) m_ovf = 1;
    else if (ts) m_ovf = 0;
    if (cp) m_carry = bs;
    else if (en && !m_pend) m_carry = 0;
    if (en) m_pend = 0;
    else if (cp) m_pend = 1;
    e.ovf = m_ovf;
    e.carry = m_carry;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0,0,0,0,0,0,0, 0,0,0,0, 16'h0000, 16'h0000, tag);
  endtask

  // Monitor: combinational outputs just before the edge, registered ones just after.
  always @(posedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      bit c_in, b_clr;
      e = exp_q.pop_front();
      c_in = carry_in;
      b_clr = b_sign_clr;
      #1;
      checks++;
      if (ovf_q !== e.ovf || carry_q !== e.carry || skip_req !== e.skip ||
          c_in !== e.cin || b_clr !== e.bclr) begin
        failures++;
        $display("FAIL %s: got ovf=%b carry=%b skip=%b cin=%b bclr=%b exp ovf=%b carry=%b skip=%b cin=%b bclr=%b",
                 e.tag, ovf_q, carry_q, skip_req, c_in, b_clr,
                 e.ovf, e.carry, e.skip, e.cin, e.bclr);
      end
    end
  end

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ovf_q !== 0 || carry_q !== 0 || skip_req !== 0) begin
      failures++;
      $display("FAIL R1 reset: got ovf=%b carry=%b skip=%b exp 0 0 0", ovf_q, carry_q, skip_req);
    end
    rst_n = 1'b1;
    idle("R1 first cycle after reset");
    // R2 add overflow
    drive(1,0,0,0,0,0,1, 0,0,0,0, 0,0, "R2 add in range");
    drive(1,0,0,0,0,0,1, 1,0,1,0, 0,0, "R2 mixed signs never wrap");
    drive(1,0,0,0,0,0,1, 0,0,1,0, 0,0, "R2 positive wrap");
    // R6 sticky
    idle("R6 holds while idle");
    drive(1,0,0,0,0,0,1, 0,0,0,0, 0,0, "R6 clean add keeps flag");
    // R7 test
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 test with flag set, no skip");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 test with flag clear, skip");
    idle("R7 skip lasts one cycle");
    // R3 subtract
    drive(0,1,0,0,0,0,1, 0,0,1,0, 0,0, "R3 same signs never wrap");
    drive(0,1,0,0,0,0,1, 0,1,1,0, 0,0, "R3 positive minus negative wraps");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear after subtract");
    drive(0,1,0,0,0,0,1, 1,0,0,0, 0,0, "R3 negative minus positive wraps");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear");
    // R5 forced set, and set against test
    drive(0,0,0,1,0,0,1, 0,0,0,0, 0,0, "R5 forced set");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear after forced");
    drive(0,0,0,1,1,0,1, 0,0,0,0, 0,0, "R7 set beats test, skip from old flag");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear");
    // R4 divide
    drive(0,0,1,0,0,0,1, 0,0,0,0, 16'h0010, 16'h0020, "R4 divisor larger");
    drive(0,0,1,0,0,0,1, 0,0,0,0, 16'h0010, 16'h0010, "R4 equal magnitude");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear");
    drive(0,0,1,0,0,0,1, 0,0,0,0, 16'h0010, 16'hFFF0, "R4 negative divisor");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear");
    drive(0,0,1,0,0,0,1, 0,0,0,0, 16'h7FFF, 16'h8000, "R4 most negative divisor");
    drive(0,0,1,0,0,0,1, 0,0,0,0, 16'hFFEF, 16'h0010, "R4 negative high word");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear");
    drive(0,0,1,0,0,0,1, 0,0,0,0, 16'h0000, 16'h0000, "R4 zero divisor");
    drive(0,0,0,0,1,0,1, 0,0,0,0, 0,0, "R7 clear");
    // R8 R9 R10 carry chain
    drive(0,0,0,0,0,1,1, 0,0,0,1, 0,0, "R8 copy sign one");
    drive(1,0,0,0,0,0,1, 0,0,0,0, 0,0, "R9 add takes carry, R10 wipe");
    drive(0,1,0,0,0,0,1, 0,0,0,0, 0,0, "R9 plain subtract carries one");
    drive(0,0,0,0,0,1,1, 0,0,0,1, 0,0, "R8 copy sign one again");
    drive(0,1,0,0,0,0,1, 0,0,0,0, 0,0, "R9 subtract takes borrow");
    drive(0,0,0,0,0,1,1, 0,0,0,0, 0,0, "R8 copy sign zero");
    drive(0,0,0,0,0,1,0, 0,0,0,1, 0,0, "R8 copy without end");
    drive(0,0,0,0,0,0,1, 0,0,0,0, 0,0, "R10 end after copy keeps carry");
    idle("R10 hold with no strobe");
    drive(1,0,0,0,0,0,1, 0,0,0,0, 0,0, "R10 next end wipes");
    drive(0,0,0,0,0,0,1, 0,0,0,0, 0,0, "R10 end on clear carry");
    idle("drain");
    idle("drain");
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule